// File: doc/BRIEF.md
# Endian-Switchable Byte-Addressed Word Memory

This block is a small synchronous store organised as 32-bit words but addressed one byte at a time. A request is a word or a single byte, read or write. A run-time input chooses how the four bytes of a word map onto the four consecutive byte addresses, so the same storage can be viewed in big-endian or little-endian order. The byte at address 4k+j always sits in physical lane j of word k. The mode only changes how a 32-bit value is spread over those lanes, or gathered back from them.

A word request whose byte address is not a multiple of four covers the tail of one word and the head of the next. A parameter fixes how such a request is handled. In split mode the request takes two cycles, and `busy` shows the second cycle. In reject mode the request is refused with a one-cycle `err` pulse and leaves the memory as it was. The controller has two states. `ST_IDLE` accepts requests. `ST_SECOND` finishes the part of a split access that falls in the following word. The transition `ST_IDLE -> ST_SECOND` is taken on an accepted unaligned word request in split mode. The transition `ST_SECOND -> ST_IDLE` is always taken after one cycle.

Top module: `endian_byte_mem`

## Requirements
- R1: After reset, every byte of the memory reads as zero, and `rd_valid`, `busy` and `err` are low.
- R2: In big-endian mode (`big_endian`=1), an aligned word write of W to address A places W[31:24] at A, W[23:16] at A+1, W[15:8] at A+2 and W[7:0] at A+3.
- R3: In little-endian mode (`big_endian`=0), an aligned word write of W to address A places W[7:0] at A, W[15:8] at A+1, W[23:16] at A+2 and W[31:24] at A+3.
- R4: A byte write (`req_byte`=1) stores `req_wdata[7:0]` at the addressed byte only, and all other bytes keep their values. A byte read returns that byte in `rd_data[7:0]`, with `rd_data[31:24]`, `rd_data[23:16]` and `rd_data[15:8]` all zero.
- R5: A request is accepted on a rising edge where `req_valid`=1 and `busy`=0. An accepted aligned word read or byte read raises `rd_valid` for exactly the cycle after the accepting edge. For a word read, the data is assembled from bytes A..A+3 using the inverse of the R2/R3 mapping for the mode sampled at acceptance.
- R6: The mode applies per request, so a word written in one mode and read in the other comes back with its four bytes reversed.
- R7: In split mode (`SPLIT`=1), an accepted word request with `req_addr[1:0]`≠0 raises `busy` for exactly the next cycle. It covers byte addresses A..A+3 modulo the memory size, so it wraps from the last word to word 0.
- R8: In split mode, an unaligned word read raises `rd_valid` two cycles after the accepting edge, with data assembled from bytes A..A+3 as in R5.
- R9: In reject mode (`SPLIT`=0), an accepted unaligned word request pulses `err` in the next cycle, gives no `rd_valid`, never raises `busy`, and changes no byte.
- R10: A request presented while `busy`=1 is ignored and changes no byte.
- R11: A write never produces `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all storage |
| big_endian | input | 1 | 1 = big-endian byte placement, 0 = little-endian |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single byte, 0 = 32-bit word |
| req_addr | input | ADDR_W (6) | Byte address |
| req_wdata | input | 32 | Write data; bits 7:0 for a byte write |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| busy | output | 1 | Second cycle of a split access; requests are ignored |
| err | output | 1 | Unaligned word request refused (reject mode) |

## Verification
Two functions can meet in one cycle: finishing the second half of a split access, and arrival of a new request. The bench issues a byte write immediately after an unaligned split write, so the new request lands in the `busy` cycle. It then reads the affected bytes back. The split data must be intact and the ignored byte must be absent. A second instance in reject mode gets the same stimulus. That instance is never busy, so it must accept the follow-up write and refuse the unaligned one. A reference byte model for each instance judges the read-backs.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } ebm_state_e;

    // Element i of the sequence is the byte destined for address A+i.
    function automatic logic [3:0][7:0] word_to_seq(input logic [31:0] w, input logic be);
        logic [3:0][7:0] s;
        for (int i = 0; i < 4; i++) begin
            s[i] = be ? w[8*(3-i) +: 8] : w[8*i +: 8];
        end
        return s;
    endfunction

    function automatic logic [31:0] seq_to_word(input logic [3:0][7:0] s, input logic be);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 4; i++) begin
            if (be) w[8*(3-i) +: 8] = s[i];
            else    w[8*i +: 8]     = s[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/ebm_store.sv
module ebm_store #(
    parameter int WORDS = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      idx,
    input  logic [3:0]            lane_we,
    input  logic [3:0][7:0]       lane_wd,
    output logic [3:0][7:0]       rd_lanes
);

    logic [WORDS-1:0][31:0] flat;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [3:0][7:0] cell_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (idx == IDX_W'(w)) begin
                for (int j = 0; j < 4; j++) begin
                    if (lane_we[j]) cell_q[j] <= lane_wd[j];
                end
            end
        end
        assign flat[w] = cell_q;
    end

    assign rd_lanes = flat[idx];

endmodule

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
    import ebm_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter bit SPLIT = 1'b1,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               big_endian,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_byte,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [3:0][7:0]    rd_lanes,
    output logic [IDX_W-1:0]   mem_idx,
    output logic [3:0]         lane_we,
    output logic [3:0][7:0]    lane_wd,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               busy,
    output logic               err
);

    ebm_state_e state_q, state_nx;

    logic [IDX_W-1:0]  p_idx;
    logic [1:0]        p_off;
    logic              p_write;
    logic              p_be;
    logic [3:0][7:0]   p_seq;

    logic              accept, unal;
    logic [1:0]        off;
    logic [IDX_W-1:0]  widx;
    logic [3:0][7:0]   seq_in, first_seq, split_seq;
    logic              rd_valid_q, err_q;
    logic [31:0]       rd_data_q;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign off    = req_addr[1:0];
    assign widx   = req_addr[ADDR_W-1:2];
    assign unal   = !req_byte && (off != 2'd0);
    assign seq_in = word_to_seq(req_wdata, big_endian);

    // Byte gathering for both halves of a split read.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            first_seq[i] = rd_lanes[2'(i) + off];
            if (i + int'(p_off) >= 4) split_seq[i] = rd_lanes[2'(i) + p_off];
            else                      split_seq[i] = p_seq[i];
        end
    end

    // Storage port steering.
    always_comb begin
        lane_we = '0;
        lane_wd = '0;
        mem_idx = widx;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && req_write) begin
                    if (req_byte) begin
                        lane_we[off] = 1'b1;
                        lane_wd[off] = req_wdata[7:0];
                    end else if (!unal || SPLIT) begin
                        for (int j = 0; j < 4; j++) begin
                            if (2'(j) >= off) begin
                                lane_we[j] = 1'b1;
                                lane_wd[j] = seq_in[2'(j) - off];
                            end
                        end
                    end
                end
            end
            ST_SECOND: begin
                mem_idx = p_idx;
                if (p_write) begin
                    for (int j = 0; j < 4; j++) begin
                        if (2'(j) < p_off) begin
                            lane_we[j] = 1'b1;
                            lane_wd[j] = p_seq[2'(j) - p_off];
                        end
                    end
                end
            end
        endcase
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && unal && SPLIT) state_nx = ST_SECOND;
            ST_SECOND: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            err_q      <= 1'b0;
            rd_data_q  <= '0;
            p_idx      <= '0;
            p_off      <= '0;
            p_write    <= 1'b0;
            p_be       <= 1'b0;
            p_seq      <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            err_q      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (unal && !SPLIT) begin
                            err_q <= 1'b1;
                        end else if (unal) begin
                            p_idx   <= widx + 1'b1;
                            p_off   <= off;
                            p_write <= req_write;
                            p_be    <= big_endian;
                            p_seq   <= req_write ? seq_in : first_seq;
                        end else if (!req_write) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= req_byte ? {24'h0, rd_lanes[off]}
                                                   : seq_to_word(rd_lanes, big_endian);
                        end
                    end
                end
                ST_SECOND: begin
                    if (!p_write) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= seq_to_word(split_seq, p_be);
                    end
                end
            endcase
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign err      = err_q;
    assign busy     = (state_q == ST_SECOND);

endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem #(
    parameter int WORDS = 16,
    parameter bit SPLIT = 1'b1,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               big_endian,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_byte,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               busy,
    output logic               err
);

    logic [IDX_W-1:0] mem_idx;
    logic [3:0]       lane_we;
    logic [3:0][7:0]  lane_wd;
    logic [3:0][7:0]  rd_lanes;

    ebm_ctrl #(.IDX_W(IDX_W), .SPLIT(SPLIT)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .big_endian (big_endian),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_byte   (req_byte),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_lanes   (rd_lanes),
        .mem_idx    (mem_idx),
        .lane_we    (lane_we),
        .lane_wd    (lane_wd),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .busy       (busy),
        .err        (err)
    );

    ebm_store #(.WORDS(WORDS)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (mem_idx),
        .lane_we  (lane_we),
        .lane_wd  (lane_wd),
        .rd_lanes (rd_lanes)
    );

endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
    parameter int ADDR_W = 6,
    parameter bit SPLIT  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_byte,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic              busy,
    input logic              err
);

    logic acc, unal;
    assign acc  = req_valid && !busy;
    assign unal = !req_byte && (req_addr[1:0] != 2'd0);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && !unal) |=> rd_valid); // R5

    AST_WR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write) |=> !rd_valid); // R11

    AST_SPLIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (SPLIT && acc && unal) |=> (busy && !err)); // R7

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R7

    AST_SPLIT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (SPLIT && acc && unal && !req_write) |=> !rd_valid ##1 rd_valid); // R8

    AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!SPLIT && acc && unal) |=> (err && !rd_valid && !busy)); // R9

    AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!rd_valid && !busy)); // R9

endmodule

bind endian_byte_mem ebm_checker #(.ADDR_W(ADDR_W), .SPLIT(SPLIT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_byte  (req_byte),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .err       (err)
);

// File: tb/endian_byte_mem_tb_top.sv
module endian_byte_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 16;
    localparam int AW    = 6;
    localparam int NB    = WORDS * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic big_endian = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;

    logic a_rd_valid, a_busy, a_err, b_rd_valid, b_busy, b_err;
    logic [31:0] a_rd_data, b_rd_data;

    typedef struct {
        bit          is_err;
        logic [31:0] data;
        int          due;
        string       tag;
    } item_t;

    item_t qa[$];
    item_t qb[$];
    logic [7:0] ref_a [NB];
    logic [7:0] ref_b [NB];
    int cyc = 0;
    int a_busy_cyc = -10;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    endian_byte_mem #(.WORDS(WORDS), .SPLIT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(a_rd_valid), .rd_data(a_rd_data),
        .busy(a_busy), .err(a_err));

    endian_byte_mem #(.WORDS(WORDS), .SPLIT(1'b0)) dut_rej_i (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
        .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(b_rd_valid), .rd_data(b_rd_data),
        .busy(b_busy), .err(b_err));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input bit which_b, input int addr, input bit byt, input bit be);
        logic [31:0] w;
        logic [7:0]  s;
        w = '0;
        if (byt) return {24'h0, which_b ? ref_b[addr % NB] : ref_a[addr % NB]};
        for (int i = 0; i < 4; i++) begin
            s = which_b ? ref_b[(addr + i) % NB] : ref_a[(addr + i) % NB];
            if (be) w[8*(3-i) +: 8] = s;
            else    w[8*i +: 8]     = s;
        end
        return w;
    endfunction

    task automatic model_write(input bit which_b, input int addr, input bit byt, input logic [31:0] d, input bit be);
        logic [7:0] s;
        if (byt) begin
            if (which_b) ref_b[addr % NB] = d[7:0];
            else         ref_a[addr % NB] = d[7:0];
        end else begin
            for (int i = 0; i < 4; i++) begin
                s = be ? d[8*(3-i) +: 8] : d[8*i +: 8];
                if (which_b) ref_b[(addr + i) % NB] = s;
                else         ref_a[(addr + i) % NB] = s;
            end
        end
    endtask

    // Driver: presents one request for one cycle and records expectations.
    task automatic issue(input bit wr, input bit byt, input int addr, input logic [31:0] d,
                         input bit be, input string tag);
        bit unal, acc_a;
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_byte = byt;
        req_addr = AW'(addr); req_wdata = d; big_endian = be;
        unal  = !byt && (addr % 4) != 0;
        acc_a = (cyc != a_busy_cyc);
        if (acc_a) begin
            if (wr) model_write(1'b0, addr, byt, d, be);
            else begin
                it.is_err = 1'b0; it.data = model_read(1'b0, addr, byt, be);
                it.due = cyc + 1 + (unal ? 1 : 0); it.tag = tag;
                qa.push_back(it);
            end
            if (unal) a_busy_cyc = cyc + 1;
        end
        if (unal) begin
            it.is_err = 1'b1; it.data = '0; it.due = cyc + 1; it.tag = {tag, " R9"};
            qb.push_back(it);
        end else if (wr) begin
            model_write(1'b1, addr, byt, d, be);
        end else begin
            it.is_err = 1'b0; it.data = model_read(1'b1, addr, byt, be);
            it.due = cyc + 1; it.tag = tag;
            qb.push_back(it);
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitors: pop the scoreboard as results appear.
    always @(negedge clk) begin
        item_t it;
        if (rst_n && !done) begin
            if (a_rd_valid || a_err) begin
                if (qa.size() == 0) chk(1'b0, "R11 unexpected output on split instance", a_rd_data, 32'h0);
                else begin
                    it = qa.pop_front();
                    chk(it.is_err == a_err && it.due == cyc, {it.tag, " timing"}, cyc, it.due);
                    if (!it.is_err) chk(a_rd_data == it.data, it.tag, a_rd_data, it.data);
                end
            end else if (qa.size() > 0 && qa[0].due < cyc) begin
                it = qa.pop_front();
                chk(1'b0, {it.tag, " missing result"}, 32'h0, it.due);
            end
            if (a_busy != (cyc == a_busy_cyc)) chk(1'b0, "R7 busy", a_busy, (cyc == a_busy_cyc));
            else if (a_busy) chk(1'b1, "R7 busy", a_busy, 1);
        end
    end

    always @(negedge clk) begin
        item_t it;
        if (rst_n && !done) begin
            if (b_rd_valid || b_err) begin
                if (qb.size() == 0) chk(1'b0, "R11 unexpected output on reject instance", b_rd_data, 32'h0);
                else begin
                    it = qb.pop_front();
                    chk(it.is_err == b_err && it.due == cyc, {it.tag, " timing/kind"}, cyc, it.due);
                    if (!it.is_err) chk(b_rd_data == it.data, it.tag, b_rd_data, it.data);
                end
            end else if (qb.size() > 0 && qb[0].due < cyc) begin
                it = qb.pop_front();
                chk(1'b0, {it.tag, " missing result"}, 32'h0, it.due);
            end
            if (b_busy) chk(1'b0, "R9 reject instance busy", b_busy, 0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin ref_a[i] = 8'h0; ref_b[i] = 8'h0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet outputs after reset
        chk(!a_rd_valid && !a_busy && !a_err, "R1 outputs after reset",
            {a_rd_valid, a_busy, a_err}, 32'h0);
        issue(0, 0, 0,  32'h0, 1, "R1 word 0 zero");
        issue(0, 0, 60, 32'h0, 0, "R1 last word zero");

        // R2: big-endian placement
        issue(1, 0, 0, 32'h201F539A, 1, "R2 write");
        idle(1);
        chk(!a_rd_valid, "R11 no rd_valid after write", a_rd_valid, 0);
        for (int i = 0; i < 4; i++) issue(0, 1, i, 32'h0, 1, "R2 byte readback");

        // R3: little-endian placement
        issue(1, 0, 4, 32'h201F539A, 0, "R3 write");
        for (int i = 4; i < 8; i++) issue(0, 1, i, 32'h0, 0, "R3 byte readback");

        // R5 / R6: word reads in both modes
        issue(0, 0, 0, 32'h0, 1, "R5 word read BE");
        issue(0, 0, 0, 32'h0, 0, "R6 cross-mode read");
        issue(0, 0, 4, 32'h0, 1, "R6 cross-mode read LE-written");

        // R4: single byte write leaves neighbours
        issue(1, 1, 2, 32'hFFFFFF77, 1, "R4 byte write");
        issue(0, 0, 0, 32'h0, 1, "R4 word after byte write");
        issue(0, 1, 3, 32'h0, 0, "R4 neighbour byte");

        // R7 / R9: unaligned write, then readback
        issue(1, 0, 9, 32'hA1B2C3D4, 1, "R7 split write");
        idle(2);
        for (int i = 8; i < 14; i++) issue(0, 1, i, 32'h0, 1, "R7 split bytes / R9 unchanged");
        issue(0, 0, 8,  32'h0, 1, "R7 word 2");
        issue(0, 0, 12, 32'h0, 0, "R7 word 3");

        // R10: request arrives during busy cycle
        issue(1, 0, 17, 32'h11223344, 1, "R7 split write two");
        issue(1, 1, 17, 32'h00000055, 1, "R10 write during busy");
        idle(2);
        for (int i = 16; i < 22; i++) issue(0, 1, i, 32'h0, 1, "R10 ignored write check");

        // R8: unaligned reads in both modes
        issue(0, 0, 9,  32'h0, 1, "R8 split read BE");
        idle(1);
        issue(0, 0, 10, 32'h0, 0, "R8 split read LE");
        idle(1);
        issue(0, 0, 3,  32'h0, 1, "R8 split read offset 3");
        idle(1);

        // R7: wrap from last word to word 0
        issue(1, 0, 62, 32'hDEADBEEF, 0, "R7 wrap write");
        idle(1);
        issue(0, 0, 0,  32'h0, 0, "R7 wrap word 0");
        issue(0, 0, 60, 32'h0, 0, "R7 wrap last word");
        issue(0, 0, 62, 32'h0, 1, "R8 wrap split read");
        idle(1);
        issue(0, 0, 62, 32'h0, 0, "R8 wrap split read LE");

        idle(5);
        chk(qa.size() == 0 && qb.size() == 0, "R5 all results delivered",
            qa.size() + qb.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule